// File: doc/BRIEF.md
# Sort-Trap Omega Cell Fabric

This block is a synchronous, self-routing N-by-N cell switch for a small number of ports (eight by default). In every clock cycle each input lane may present one cell made of a destination port number and a fixed-width data word. The block first orders all cells by destination and sends idle lanes to the end. It then removes every cell whose destination repeats an earlier one. The surviving cells are packed into the lowest lanes, and a multistage network of 2x2 self-routing elements delivers each of them to its output port.

Because the cells reach the routing network ordered, unique and with no gaps, the network never has two cells competing for one element output. Cells removed as duplicates are not delivered. They are presented packed on a separate set of recirculation lanes, so that the surrounding logic can offer them again in a later cycle. Every result is registered, so inputs sampled at one rising clock edge appear on the outputs directly after that edge.

Top module: `stb_fabric`

## Requirements
- R1: A valid cell whose destination is used by no other valid cell appears on output port `dest`, with `out_valid` set and its data word on that port's slice of `out_data`, in the register update at the same rising edge that samples the inputs.
- R2: When several valid cells share a destination, only the cell from the lowest-numbered input lane is delivered on that port.
- R3: Cells that lose under R2 appear on recirculation lanes 0 to t-1, where t is the number of losers. They are ordered by ascending destination and, within one destination, by ascending input lane, and each carries its destination and data. `rc_valid` therefore always has the form 2^t-1.
- R4: Idle input lanes (`in_valid` bit clear) are never delivered and never recirculated. The number of set `out_valid` bits plus the number of set `rc_valid` bits equals the number of valid inputs.
- R5: An output port or recirculation lane that carries no cell shows all-zero data, and an unused recirculation lane also shows destination 0.
- R6: While reset is asserted, and at the first edge after it is released, `out_valid` and `rc_valid` are all zero.
- R7: No 2x2 element in the routing network ever receives two cells that need the same element output.
- R8: Input lane i uses bits [i*AW +: AW] of `in_dest` and bits [i*DW +: DW] of `in_data`. Output port p and recirculation lane p use the same slicing. The routing stage with index s steers on destination bit AW-1-s, sending a cell to the upper element output when that bit is 0.

Parameters: `N` ports (a power of two), `DW` data bits. AW = log2 N.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | N | Per-lane cell present flag |
| in_dest | input | N*AW | Per-lane destination port number |
| in_data | input | N*DW | Per-lane data word |
| out_valid | output | N | Per-port delivered-cell flag |
| out_data | output | N*DW | Per-port delivered data, zero when idle |
| rc_valid | output | N | Recirculation lane occupied flags, packed from lane 0 |
| rc_dest | output | N*AW | Destination of each recirculated cell |
| rc_data | output | N*DW | Data of each recirculated cell |

## Verification
The hardest condition to create is a routing-network input in which a packed, ordered set of distinct destinations has holes in the destination space and starts away from port 0. These sets put two cells into one element in the middle stages, and only the combined effect of sorting, trapping and packing keeps them apart. The stimulus reaches these sets by going through all 256 lane-occupancy masks. Each mask is combined with several destination patterns: identity, reversed, all lanes to one port, pairs of lanes sharing a port, an affine pattern and a pseudo-random one. Masked-off lanes then leave irregular gaps, and every duplicate count from 0 to 7 comes up. For each vector the bench computes the expected winners and the ordered recirculation list from the lane numbers alone.

// File: rtl/stb_pkg.sv
package stb_pkg;

    // Steering decision of a 2x2 element, taken from one destination bit.
    typedef enum logic {
        PORT_UPPER = 1'b0,
        PORT_LOWER = 1'b1
    } port_sel_e;

    // Perfect-shuffle wiring seen from the receiving side: the lane that
    // feeds position q is q rotated right by one bit within 'bits' bits.
    function automatic int unsigned shuffle_src(int unsigned q, int unsigned bits);
        int unsigned low;
        low = q & 1;
        return (q >> 1) | (low << (bits - 1));
    endfunction

endpackage

// File: rtl/stb_bitonic_sorter.sv
// Combinational bitonic sorter over packed cell words. Cell words compare
// as unsigned numbers; the caller places the sort key in the upper bits.
module stb_bitonic_sorter #(
    parameter int unsigned N  = 8,
    parameter int unsigned CW = 15
) (
    input  logic [N*CW-1:0] cells_i,
    output logic [N*CW-1:0] cells_o
);

    logic [CW-1:0] work_d [N];
    logic [CW-1:0] swap_d;

    always_comb begin
        for (int i = 0; i < int'(N); i++) begin
            work_d[i] = cells_i[i*CW +: CW];
        end
        swap_d = '0;
        // Build ascending/descending runs of size k, merge them, double k.
        for (int k = 2; k <= int'(N); k = k * 2) begin
            for (int j = k / 2; j > 0; j = j / 2) begin
                for (int i = 0; i < int'(N); i++) begin
                    if ((i ^ j) > i) begin
                        if ((((i & k) == 0) && (work_d[i] > work_d[i ^ j])) ||
                            (((i & k) != 0) && (work_d[i] < work_d[i ^ j]))) begin
                            swap_d         = work_d[i];
                            work_d[i]      = work_d[i ^ j];
                            work_d[i ^ j]  = swap_d;
                        end
                    end
                end
            end
        end
        for (int i = 0; i < int'(N); i++) begin
            cells_o[i*CW +: CW] = work_d[i];
        end
    end

endmodule

// File: rtl/stb_trap_compact.sv
// Splits a sorted cell stream into first-of-destination survivors and
// repeated-destination losers, each packed toward lane 0 in sorted order.
module stb_trap_compact #(
    parameter int unsigned N  = 8,
    parameter int unsigned CW = 15,
    parameter int unsigned AW = 3
) (
    input  logic [N*CW-1:0] sorted_i,
    output logic [N*CW-1:0] kept_o,
    output logic [N*CW-1:0] trapped_o
);

    localparam logic [CW-1:0] IDLE_CELL = {1'b1, {(CW-1){1'b0}}};

    logic [CW-1:0] cell_d;
    logic [AW-1:0] prev_dest_d;
    logic          prev_live_d;
    logic          repeat_d;
    int            kept_n_d;
    int            trap_n_d;

    always_comb begin
        kept_o      = {N{IDLE_CELL}};
        trapped_o   = {N{IDLE_CELL}};
        kept_n_d    = 0;
        trap_n_d    = 0;
        prev_dest_d = '0;
        prev_live_d = 1'b0;
        cell_d      = IDLE_CELL;
        repeat_d    = 1'b0;
        for (int i = 0; i < int'(N); i++) begin
            cell_d = sorted_i[i*CW +: CW];
            if (!cell_d[CW-1]) begin
                repeat_d = prev_live_d && (prev_dest_d == cell_d[CW-2 -: AW]);
                if (repeat_d) begin
                    trapped_o[trap_n_d*CW +: CW] = cell_d;
                    trap_n_d = trap_n_d + 1;
                end else begin
                    kept_o[kept_n_d*CW +: CW] = cell_d;
                    kept_n_d = kept_n_d + 1;
                end
            end
            prev_live_d = !cell_d[CW-1];
            prev_dest_d = cell_d[CW-2 -: AW];
        end
    end

endmodule

// File: rtl/stb_switch2.sv
// One 2x2 self-routing element: a destination bit of 0 goes up, 1 goes down.
module stb_switch2 #(
    parameter int unsigned CW     = 15,
    parameter int unsigned SELPOS = 13
) (
    input  logic [CW-1:0] up_i,
    input  logic [CW-1:0] dn_i,
    output logic [CW-1:0] up_o,
    output logic [CW-1:0] dn_o,
    output logic          clash_o
);
    import stb_pkg::*;

    localparam logic [CW-1:0] IDLE_CELL = {1'b1, {(CW-1){1'b0}}};

    logic      a_live, b_live;
    port_sel_e a_sel, b_sel;

    always_comb begin
        a_live  = !up_i[CW-1];
        b_live  = !dn_i[CW-1];
        a_sel   = port_sel_e'(up_i[SELPOS]);
        b_sel   = port_sel_e'(dn_i[SELPOS]);
        up_o    = IDLE_CELL;
        dn_o    = IDLE_CELL;
        if (a_live && a_sel == PORT_UPPER)      up_o = up_i;
        else if (b_live && b_sel == PORT_UPPER) up_o = dn_i;
        if (a_live && a_sel == PORT_LOWER)      dn_o = up_i;
        else if (b_live && b_sel == PORT_LOWER) dn_o = dn_i;
        clash_o = a_live && b_live && (a_sel == b_sel);
    end

endmodule

// File: rtl/stb_omega.sv
// log2(N) columns, each a perfect shuffle followed by N/2 2x2 elements.
module stb_omega #(
    parameter int unsigned N  = 8,
    parameter int unsigned CW = 15,
    parameter int unsigned AW = 3
) (
    input  logic [N*CW-1:0] cells_i,
    output logic [N*CW-1:0] ports_o,
    output logic            clash_o
);

    localparam int unsigned HALF = N / 2;

    logic [AW-1:0][HALF-1:0] clash_map;

    for (genvar s = 0; s < AW; s++) begin : g_stage
        logic [N*CW-1:0] src;
        logic [N*CW-1:0] shuf;
        logic [N*CW-1:0] dst;

        if (s == 0) begin : g_first
            assign src = cells_i;
        end else begin : g_next
            assign src = g_stage[s-1].dst;
        end

        for (genvar q = 0; q < N; q++) begin : g_wire
            localparam int unsigned FROM = stb_pkg::shuffle_src(q, AW);
            assign shuf[q*CW +: CW] = src[FROM*CW +: CW];
        end

        for (genvar e = 0; e < HALF; e++) begin : g_elem
            stb_switch2 #(
                .CW     (CW),
                .SELPOS (CW - 2 - s)
            ) u_sw (
                .up_i    (shuf[(2*e)*CW +: CW]),
                .dn_i    (shuf[(2*e+1)*CW +: CW]),
                .up_o    (dst[(2*e)*CW +: CW]),
                .dn_o    (dst[(2*e+1)*CW +: CW]),
                .clash_o (clash_map[s][e])
            );
        end
    end

    assign ports_o = g_stage[AW-1].dst;
    assign clash_o = |clash_map;

endmodule

// File: rtl/stb_fabric.sv
module stb_fabric #(
    parameter int unsigned N  = 8,
    parameter int unsigned DW = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [N-1:0]              in_valid,
    input  logic [N*$clog2(N)-1:0]    in_dest,
    input  logic [N*DW-1:0]           in_data,
    output logic [N-1:0]              out_valid,
    output logic [N*DW-1:0]           out_data,
    output logic [N-1:0]              rc_valid,
    output logic [N*$clog2(N)-1:0]    rc_dest,
    output logic [N*DW-1:0]           rc_data
);

    localparam int unsigned AW = $clog2(N);
    localparam int unsigned LW = AW;
    // Cell word, MSB first: idle flag, destination, source lane, data.
    localparam int unsigned CW = 1 + AW + LW + DW;
    localparam int unsigned DEST_LSB = DW + LW;

    typedef struct packed {
        logic              live;
        logic [N-1:0]      out_valid;
        logic [N*DW-1:0]   out_data;
        logic [N-1:0]      rc_valid;
        logic [N*AW-1:0]   rc_dest;
        logic [N*DW-1:0]   rc_data;
    } state_t;

    state_t state_d, state_q;

    logic [N*CW-1:0] raw_cells;
    logic [N*CW-1:0] sorted_cells;
    logic [N*CW-1:0] kept_cells;
    logic [N*CW-1:0] trap_cells;
    logic [N*CW-1:0] port_cells;
    logic            fabric_clash;

    for (genvar i = 0; i < N; i++) begin : g_pack
        assign raw_cells[i*CW +: CW] = {~in_valid[i], in_dest[i*AW +: AW],
                                        LW'(i), in_data[i*DW +: DW]};
    end

    stb_bitonic_sorter #(.N(N), .CW(CW)) u_sort (
        .cells_i (raw_cells),
        .cells_o (sorted_cells)
    );

    stb_trap_compact #(.N(N), .CW(CW), .AW(AW)) u_trap (
        .sorted_i  (sorted_cells),
        .kept_o    (kept_cells),
        .trapped_o (trap_cells)
    );

    stb_omega #(.N(N), .CW(CW), .AW(AW)) u_net (
        .cells_i (kept_cells),
        .ports_o (port_cells),
        .clash_o (fabric_clash)
    );

    always_comb begin
        state_d      = '0;
        state_d.live = 1'b1;
        for (int p = 0; p < int'(N); p++) begin
            if (!port_cells[p*CW + CW - 1]) begin
                state_d.out_valid[p]          = 1'b1;
                state_d.out_data[p*DW +: DW]  = port_cells[p*CW +: DW];
            end
            if (!trap_cells[p*CW + CW - 1]) begin
                state_d.rc_valid[p]           = 1'b1;
                state_d.rc_dest[p*AW +: AW]   = trap_cells[p*CW + DEST_LSB +: AW];
                state_d.rc_data[p*DW +: DW]   = trap_cells[p*CW +: DW];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign out_valid = state_q.out_valid;
    assign out_data  = state_q.out_data;
    assign rc_valid  = state_q.rc_valid;
    assign rc_dest   = state_q.rc_dest;
    assign rc_data   = state_q.rc_data;

    // R7: the packed, ordered, unique stream never collides in an element.
    assert_no_block_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !fabric_clash);

    // R1: whatever the network puts on a port is addressed to that port.
    for (genvar p = 0; p < N; p++) begin : g_chk_port
        assert_port_match_R1: assert property (@(posedge clk) disable iff (!rst_n)
            !port_cells[p*CW + CW - 1] |-> port_cells[p*CW + DEST_LSB +: AW] == AW'(p));
    end

    // R2: sorter output is strictly ascending in (idle, dest, lane).
    for (genvar i = 0; i + 1 < N; i++) begin : g_chk_sort
        assert_sorted_R2: assert property (@(posedge clk) disable iff (!rst_n)
            sorted_cells[i*CW +: CW] < sorted_cells[(i+1)*CW +: CW]);
    end

    // R3: recirculation lanes are filled from lane 0 without holes.
    assert_rc_packed_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q.rc_valid & (state_q.rc_valid + N'(1))) == '0);

    // R4: every valid input is either delivered or recirculated, once.
    assert_conserve_R4: assert property (@(posedge clk) disable iff (!rst_n)
        state_q.live |-> ($countones(state_q.out_valid) + $countones(state_q.rc_valid)
                          == $past($countones(in_valid))));

    // R6: nothing is presented at the first edge after reset release.
    assert_reset_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (state_q.out_valid == '0 && state_q.rc_valid == '0));

endmodule

// File: tb/stb_fabric_test.sv
module stb_fabric_test;

    localparam int N  = 8;
    localparam int AW = 3;
    localparam int DW = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [N-1:0]      in_valid = '0;
    logic [N*AW-1:0]   in_dest = '0;
    logic [N*DW-1:0]   in_data = '0;
    logic [N-1:0]      out_valid;
    logic [N*DW-1:0]   out_data;
    logic [N-1:0]      rc_valid;
    logic [N*AW-1:0]   rc_dest;
    logic [N*DW-1:0]   rc_data;

    int compared = 0;
    int mismatched = 0;
    logic [15:0] lfsr = 16'hACE1;

    always #4 clk = ~clk;

    stb_fabric #(.N(N), .DW(DW)) uut (
        .clk (clk), .rst_n (rst_n),
        .in_valid (in_valid), .in_dest (in_dest), .in_data (in_data),
        .out_valid (out_valid), .out_data (out_data),
        .rc_valid (rc_valid), .rc_dest (rc_dest), .rc_data (rc_data)
    );

    task automatic report();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    endtask

    // Compute expected outputs from the requirements and compare.
    task automatic check_vector(input int tag);
        logic [N-1:0]    e_ov = '0;
        logic [N*DW-1:0] e_od = '0;
        logic [N-1:0]    e_rv = '0;
        logic [N*AW-1:0] e_rd = '0;
        logic [N*DW-1:0] e_rdat = '0;
        logic [N-1:0]    won = '0;
        int t = 0;
        // R1/R2: lowest valid lane per destination wins
        for (int d = 0; d < N; d++) begin
            for (int l = 0; l < N; l++) begin
                if (in_valid[l] && int'(in_dest[l*AW +: AW]) == d && !e_ov[d]) begin
                    e_ov[d] = 1'b1;
                    e_od[d*DW +: DW] = in_data[l*DW +: DW];
                    won[l] = 1'b1;
                end
            end
        end
        // R3: losers packed by (dest, lane)
        for (int d = 0; d < N; d++) begin
            for (int l = 0; l < N; l++) begin
                if (in_valid[l] && int'(in_dest[l*AW +: AW]) == d && !won[l]) begin
                    e_rv[t] = 1'b1;
                    e_rd[t*AW +: AW] = AW'(d);
                    e_rdat[t*DW +: DW] = in_data[l*DW +: DW];
                    t++;
                end
            end
        end
        compared++;
        if (out_valid !== e_ov || out_data !== e_od) begin
            mismatched++;
            $display("FAIL R1/R2/R5/R8 vec %0d: out_valid=%h out_data=%h expected %h %h",
                     tag, out_valid, out_data, e_ov, e_od);
        end
        compared++;
        if (rc_valid !== e_rv || rc_dest !== e_rd || rc_data !== e_rdat) begin
            mismatched++;
            $display("FAIL R3/R4/R5 vec %0d: rc_valid=%h rc_dest=%h rc_data=%h expected %h %h %h",
                     tag, rc_valid, rc_dest, rc_data, e_rv, e_rd, e_rdat);
        end
    endtask

    initial begin : watchdog
        #(200000 * 8);
        mismatched++;
        $display("FAIL watchdog: run did not complete, actual hung expected done");
        report();
        $finish;
    end

    initial begin : stimulus
        int vec = 0;
        repeat (3) @(negedge clk);
        // R6: idle during reset
        compared++;
        if (out_valid !== '0 || rc_valid !== '0) begin
            mismatched++;
            $display("FAIL R6 reset: out_valid=%h rc_valid=%h expected 0 0", out_valid, rc_valid);
        end
        rst_n = 1'b1;
        @(negedge clk);
        compared++;
        if (out_valid !== '0 || rc_valid !== '0) begin
            mismatched++;
            $display("FAIL R6 release: out_valid=%h rc_valid=%h expected 0 0", out_valid, rc_valid);
        end

        for (int m = 0; m < 256; m++) begin
            for (int pat = 0; pat < 6; pat++) begin
                in_valid = N'(m);
                for (int l = 0; l < N; l++) begin
                    int d;
                    case (pat)
                        0: d = l;
                        1: d = N - 1 - l;
                        2: d = m % N;
                        3: d = l / 2;
                        4: d = int'(lfsr[l +: 3]);
                        default: d = (l * 3 + m) % N;
                    endcase
                    in_dest[l*AW +: AW] = AW'(d);
                    in_data[l*DW +: DW] = {3'(l), 5'(vec)};
                end
                lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
                @(negedge clk);
                check_vector(vec);
                vec++;
            end
        end

        // R1/R8: the worked example lane pattern [X,2,3,X,3,X,X,X]
        in_valid = 8'b0001_0110;
        in_dest  = '0;
        in_dest[1*AW +: AW] = 3'd2;
        in_dest[2*AW +: AW] = 3'd3;
        in_dest[4*AW +: AW] = 3'd3;
        for (int l = 0; l < N; l++) in_data[l*DW +: DW] = 8'hA0 + 8'(l);
        @(negedge clk);
        check_vector(vec);

        in_valid = '0;
        @(negedge clk);
        check_vector(vec + 1);

        report();
        $finish;
    end

endmodule